// File: doc/BRIEF.md
# SPI Slave Register Port with Burst Access

This block lets an external controller reach a small byte-wide register array over a four-wire SPI link: a serial clock, data in, data out and an active-low select. Each transaction begins with one command byte. Any number of data bytes follow it, and they either write into the array or stream its contents back out. The command byte carries three things: a direction flag, an auto-step flag and a register address. With the auto-step flag set, a burst moves through consecutive registers. With it clear, the burst hits the same register every time.

The serial inputs are brought into the system clock domain through synchronizers and sampled there. The array is an ordinary dual-port memory, so the synthesis tool can map it to block RAM. For reads, the next register is fetched as soon as the previous byte completes, so data bytes go out back to back without a gap. The link runs in SPI mode 0, most significant bit first. The serial clock must be slow enough that each of its half periods spans at least six system clock cycles.

Top module: `spi_reg_slave`

## Requirements
- R1: Command bit 7 selects the direction: 1 writes the data bytes into the array and 0 reads the array out on MISO.
- R2: When command bit 6 is 1, the register address advances by one after every data byte. When it is 0, every data byte of the burst accesses the same register.
- R3: Command bits 5:0 give the register address used for the first data byte.
- R4: Bits travel MSB first. MOSI is taken on the rising SCK edge, and MISO changes only on falling SCK edges, so the MSB of a read byte is present before the first rising edge of that byte.
- R5: While SS is high, MISO is held low.
- R6: A burst may carry any number of data bytes while SS stays low, and read bytes follow one another with no idle bit between them.
- R7: An auto-stepping address wraps from 63 to 0.
- R8: A byte that is cut short by SS going high is discarded. It performs no write, and the next low period of SS starts with a new command byte.
- R9: After reset MISO is low and the port waits for a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock from the controller, idle low |
| ss_n | input | 1 | Active-low select framing a transaction |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller, low when not selected |

## Verification
A bit counter that is out of step, or that is not cleared when SS rises, moves every later byte by some bits. Such a fault shows on the first readback of a known register after the bad transaction, within about two bytes of SCK. A wrong stepping or wrap of the held address writes data to the wrong register, or returns it from the wrong one. Checking a burst read against the bench's own model shows this at the byte where the address goes astray. A late read prefetch leaves MISO one byte behind, and this appears on the first bit of the first data byte.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic ss_n,
  input  logic mosi,
  output logic ss_act,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sck_q, ss_q, mosi_q;
  logic              sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      ss_q   <= '1;
      mosi_q <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[STAGES-2:0], sck};
      ss_q   <= {ss_q[STAGES-2:0], ss_n};
      mosi_q <= {mosi_q[STAGES-2:0], mosi};
      sck_d  <= sck_q[LAST];
    end
  end

  assign ss_act   = ~ss_q[LAST];
  assign sck_rise = sck_q[LAST] & ~sck_d;
  assign sck_fall = ~sck_q[LAST] & sck_d;
  assign mosi_s   = mosi_q[LAST];
endmodule

// File: rtl/spi_reg_array.sv
module spi_reg_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ss_act,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata,
  output logic          re,
  output logic [AW-1:0] raddr,
  input  logic [DW-1:0] rdata,
  output logic          miso_o
);
  localparam int BW       = $clog2(DW);
  localparam int DIR_BIT  = DW - 1;
  localparam int STEP_BIT = DW - 2;
  localparam logic [AW-1:0] TOP_ADDR = '1;

  phase_t        phase;
  logic [BW-1:0] bit_cnt;
  logic [DW-1:0] rx_sh, tx_sh;
  logic          dir_wr, step_en, load_q;
  logic [AW-1:0] cur_addr;

  logic [DW-1:0] rx_next;
  logic          byte_done;
  logic [AW-1:0] step_addr;

  assign rx_next   = {rx_sh[DW-2:0], mosi_s};
  assign byte_done = ss_act && sck_rise && (bit_cnt == BW'(DW - 1));
  assign step_addr = step_en ? cur_addr + 1'b1 : cur_addr;

  always_comb begin
    we    = byte_done && (phase == PH_DATA) && dir_wr;
    waddr = cur_addr;
    wdata = rx_next;
    if (phase == PH_CMD) begin
      re    = byte_done && !rx_next[DIR_BIT];
      raddr = rx_next[AW-1:0];
    end else begin
      re    = byte_done && !dir_wr;
      raddr = step_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_wr   <= 1'b0;
      step_en  <= 1'b0;
      cur_addr <= '0;
    end else if (ss_act && byte_done) begin
      if (phase == PH_CMD) begin
        dir_wr   <= rx_next[DIR_BIT];
        step_en  <= rx_next[STEP_BIT];
        cur_addr <= rx_next[AW-1:0];
      end else begin
        cur_addr <= step_addr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ss_act) begin
      phase   <= PH_CMD;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      load_q  <= 1'b0;
      miso_o  <= 1'b0;
    end else begin
      load_q <= re;
      if (sck_rise) begin
        rx_sh   <= rx_next;
        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
      end
      if (byte_done && phase == PH_CMD) phase <= PH_DATA;
      if (load_q) begin
        tx_sh <= rdata;
      end else if (sck_fall && phase == PH_DATA && !dir_wr) begin
        miso_o <= tx_sh[DW-1];
        tx_sh  <= {tx_sh[DW-2:0], 1'b0};
      end
    end
  end

  p_miso_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !ss_act |=> !miso_o);

  p_miso_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ss_act && !sck_fall) |=> $stable(miso_o));

  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (we && step_en && cur_addr == TOP_ADDR) |=> (cur_addr == '0));

  p_partial_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !ss_act |=> (bit_cnt == '0 && phase == PH_CMD));

  p_single_write_r1: assert property (@(posedge clk) disable iff (rst)
    we |=> !we);
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int AW          = 6,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic ss_n,
  input  logic mosi,
  output logic miso
);
  logic          ss_act, sck_rise, sck_fall, mosi_s;
  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wdata, rdata;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .ss_act(ss_act), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
  );

  spi_reg_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .ss_act(ss_act), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .mosi_s(mosi_s), .we(we), .waddr(waddr),
    .wdata(wdata), .re(re), .raddr(raddr), .rdata(rdata), .miso_o(miso)
  );

  spi_reg_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic ss_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];

  always #5 clk = ~clk;

  spi_reg_slave dut (.clk(clk), .rst(rst), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso));

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic got);
    mosi = b;
    wait_clk(8);
    sck = 1'b1;
    got = miso;
    wait_clk(8);
    sck = 1'b0;
  endtask

  task automatic spi_xfer(input int nb, input int extra_bits);
    logic g;
    ss_n = 1'b0;
    wait_clk(8);
    for (int b = 0; b < nb; b++) begin
      for (int i = 7; i >= 0; i--) begin
        send_bit(tx_buf[b][i], g);
        rx_buf[b][i] = g;
      end
    end
    for (int i = 7; i > 7 - extra_bits; i--) send_bit(tx_buf[nb][i], g);
    wait_clk(8);
    ss_n = 1'b1;
    wait_clk(16);
  endtask

  task automatic test_reset();
    check("R9 miso after reset", {7'd0, miso}, 8'h00);
  endtask

  task automatic test_single();
    tx_buf[0] = 8'hAA; tx_buf[1] = 8'hA5; spi_xfer(2, 0);
    tx_buf[0] = 8'h95; tx_buf[1] = 8'h5A; spi_xfer(2, 0);
    tx_buf[0] = 8'h2A; tx_buf[1] = 8'h00; spi_xfer(2, 0);
    check("R1 R3 R4 read 0x2A", rx_buf[1], 8'hA5);
    check("R4 miso low in command byte", rx_buf[0], 8'h00);
    tx_buf[0] = 8'h15; spi_xfer(2, 0);
    check("R3 read 0x15", rx_buf[1], 8'h5A);
  endtask

  task automatic test_burst_inc();
    tx_buf[0] = 8'hCA;
    for (int i = 0; i < 5; i++) tx_buf[i+1] = 8'((i + 1) * 8'h11);
    spi_xfer(6, 0);
    tx_buf[0] = 8'h4A;
    spi_xfer(6, 0);
    for (int i = 0; i < 5; i++)
      check("R2 R6 burst step read", rx_buf[i+1], 8'((i + 1) * 8'h11));
  endtask

  task automatic test_no_inc();
    tx_buf[0] = 8'h95; tx_buf[1] = 8'h77; spi_xfer(2, 0);
    tx_buf[0] = 8'h94; tx_buf[1] = 8'h01; tx_buf[2] = 8'h02; tx_buf[3] = 8'h03;
    spi_xfer(4, 0);
    tx_buf[0] = 8'h14; spi_xfer(2, 0);
    check("R2 fixed write last byte", rx_buf[1], 8'h03);
    tx_buf[0] = 8'h15; spi_xfer(2, 0);
    check("R2 neighbour untouched", rx_buf[1], 8'h77);
    tx_buf[0] = 8'h0A; spi_xfer(4, 0);
    for (int i = 1; i < 4; i++) check("R2 fixed read repeats", rx_buf[i], 8'h11);
  endtask

  task automatic test_wrap();
    tx_buf[0] = 8'hFE; tx_buf[1] = 8'hE0; tx_buf[2] = 8'hE1; tx_buf[3] = 8'hE2;
    spi_xfer(4, 0);
    tx_buf[0] = 8'h00; spi_xfer(2, 0);
    check("R7 write wrapped to 0", rx_buf[1], 8'hE2);
    tx_buf[0] = 8'h7F; spi_xfer(3, 0);
    check("R7 read at 63", rx_buf[1], 8'hE1);
    check("R7 read wraps to 0", rx_buf[2], 8'hE2);
  endtask

  task automatic test_partial();
    tx_buf[0] = 8'h85; tx_buf[1] = 8'h3C; spi_xfer(2, 0);
    tx_buf[0] = 8'h85; tx_buf[1] = 8'hFF; spi_xfer(1, 5);
    tx_buf[0] = 8'h05; tx_buf[1] = 8'h00; spi_xfer(2, 0);
    check("R8 partial byte not written", rx_buf[1], 8'h3C);
    tx_buf[0] = 8'h85; tx_buf[1] = 8'hFF; spi_xfer(0, 3);
    tx_buf[0] = 8'h05; spi_xfer(2, 0);
    check("R8 partial command discarded", rx_buf[1], 8'h3C);
  endtask

  task automatic test_idle();
    tx_buf[0] = 8'hE8; tx_buf[1] = 8'hFF; tx_buf[2] = 8'h80; spi_xfer(3, 0);
    tx_buf[0] = 8'h68; spi_xfer(2, 0);
    check("R6 read before idle", rx_buf[1], 8'hFF);
    check("R5 miso low after SS high", {7'd0, miso}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    test_reset();
    test_single();
    test_burst_inc();
    test_no_inc();
    test_wrap();
    test_partial();
    test_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule